// File: doc/BRIEF.md
# Compare-Match Timer Event Channel

This block is a 16-bit event timer that a system uses for its scheduler tick and for single timed wake-ups. It advances once per pulse of a slow 32.768 kHz tick strobe (delivered as a one-cycle enable in the bus clock domain). When the count reaches a programmable compare value it raises a pending flag and, if enabled, an interrupt. In periodic mode the count then restarts from zero. In single-shot mode the channel parks until software restarts it.

Software drives the channel through a small register window. A command register enables, disables or restarts the counter. A configuration bit selects periodic or single-shot behaviour. Separate set and clear registers edit the interrupt mask. A status register reports the pending flags and clears them when read. After reset the compare value holds the periodic tick length for the `TICK_HZ` parameter, computed as (32768 + TICK_HZ/2) / TICK_HZ. The default of 100 Hz gives 328.

Top module: `evt_timer_chan`

## Requirements
- R1: After reset: count 0, counter neither enabled nor halted, pending flags 0, interrupt mask 0, single-shot bit 0, `irq` low, and the compare register holds (32768 + TICK_HZ/2) / TICK_HZ (328 for the default 100).
- R2: The count rises by exactly one on each cycle with `slow_tick` high while the counter is enabled and not halted. In every other cycle it holds its value.
- R3: In periodic mode, a tick that would bring the count to the effective compare value C instead returns the count to 0 and sets pending flag bit 0. One event therefore occurs every C ticks, without end.
- R4: When bit 0 of the configuration register (address 1) is 1, the count goes to 0 on a match and the channel halts. Later ticks have no effect until a restart command.
- R5: A write to address 0 is a command. Bit 0 enables counting, bit 1 disables it and wins over bit 0, and bit 2 restarts (count to 0, halt cleared). A `slow_tick` in the same cycle as a command write is ignored.
- R6: A compare value of 0 behaves as 1, so an enabled channel produces an event on every tick.
- R7: Writing address 3 sets the mask bits written as 1, and writing address 4 clears them (0xFF clears all). Address 5 reads back the 8-bit mask. `irq` is high when pending flag bit 0 and mask bit 0 are both 1.
- R8: Reading address 6 returns the pending flags in bits 7:0 and "counting active" (enabled and not halted) in bit 8. The read clears the flags at the next edge and holds `irq` low during the read cycle. A match in that same cycle leaves flag bit 0 set.
- R9: Reads return data in the same cycle `bus_rd` is high. Address 1 returns the mode bit in bit 0, address 2 the compare value, and address 7 the count. Addresses 0, 3 and 4, and any cycle without `bus_rd`, return 0.
- R10: The full 16-bit range works: with compare 0xFFFF the count climbs to 0xFFFE and the next tick wraps it to 0 with an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Level interrupt request |

## Verification
The channel is run with ticks every cycle, every second cycle and every third cycle. This separates counting driven by the strobe from counting driven by the bus clock, and shows whether the count holds between ticks. Periodic and single-shot runs with a short compare value tell restart apart from halting. Command writes land on tick cycles, which exposes whether a command or a tick wins. Status reads are issued back to back while a compare of zero matches on every tick, so a lost event shows up as a dropped flag. A full 0xFFFF run checks the top of the range and the wrap.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    localparam int unsigned SLOW_CLK_HZ = 32768;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RS_CMD      = 3'd0,
        RS_CFG      = 3'd1,
        RS_CMP      = 3'd2,
        RS_IRQ_SET  = 3'd3,
        RS_IRQ_CLR  = 3'd4,
        RS_IRQ_MASK = 3'd5,
        RS_STAT     = 3'd6,
        RS_COUNT    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic kick;
        logic off;
        logic on;
    } run_cmd_t;

    // Nearest-integer number of slow ticks for one period at rate hz.
    function automatic int unsigned ticks_for_rate(input int unsigned hz);
        return (SLOW_CLK_HZ + hz / 2) / hz;
    endfunction

    function automatic run_cmd_t decode_cmd(input logic [2:0] bits);
        run_cmd_t c;
        c.on   = bits[0];
        c.off  = bits[1];
        c.kick = bits[2];
        return c;
    endfunction

endpackage

// File: rtl/evt_tick_counter.sv
module evt_tick_counter
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick,
    input  logic             cmd_valid,
    input  run_cmd_t         cmd,
    input  logic             single,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             clk_en,
    output logic             halted,
    output logic             hit
);

    logic [CNT_W-1:0] cmp_eff;
    logic [CNT_W:0]   cnt_next;
    logic             running;

    always_comb begin
        cmp_eff  = (cmp == '0) ? CNT_W'(1) : cmp;
        cnt_next = {1'b0, count} + (CNT_W+1)'(1);
        running  = clk_en && !halted;
        hit      = slow_tick && running && !cmd_valid &&
                   (cnt_next >= {1'b0, cmp_eff});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            clk_en <= 1'b0;
            halted <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd.off)
                clk_en <= 1'b0;
            else if (cmd.on)
                clk_en <= 1'b1;
            if (cmd.kick) begin
                count  <= '0;
                halted <= 1'b0;
            end
        end else if (slow_tick && running) begin
            if (hit) begin
                count <= '0;
                if (single)
                    halted <= 1'b1;
            end else begin
                count <= cnt_next[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] src_evt,
    input  logic [IRQ_W-1:0] mask_set,
    input  logic [IRQ_W-1:0] mask_clr,
    input  logic             stat_rd,
    output logic [IRQ_W-1:0] flags,
    output logic [IRQ_W-1:0] mask,
    output logic             irq
);

    for (genvar g = 0; g < IRQ_W; g++) begin : g_src
        logic flag_q;
        logic mask_q;

        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (src_evt[g])
                flag_q <= 1'b1;
            else if (stat_rd)
                flag_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                mask_q <= 1'b0;
            else if (mask_set[g])
                mask_q <= 1'b1;
            else if (mask_clr[g])
                mask_q <= 1'b0;
        end

        assign flags[g] = flag_q;
        assign mask[g]  = mask_q;
    end

    assign irq = (|(flags & mask)) && !stat_rd;

endmodule

// File: rtl/evt_bus_regs.sv
module evt_bus_regs
    import evt_timer_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter int          DATA_W  = 16,
    parameter int          IRQ_W   = 8,
    parameter int unsigned RST_CMP = 328
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [CNT_W-1:0]      count,
    input  logic                  active,
    input  logic [IRQ_W-1:0]      flags,
    input  logic [IRQ_W-1:0]      mask,
    output logic                  cmd_valid,
    output run_cmd_t              cmd,
    output logic                  single,
    output logic [CNT_W-1:0]      cmp,
    output logic [IRQ_W-1:0]      mask_set,
    output logic [IRQ_W-1:0]      mask_clr,
    output logic                  stat_rd
);

    localparam int ACT_POS = IRQ_W;

    reg_sel_e sel;

    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        cmd_valid = bus_wr && (sel == RS_CMD);
        cmd       = decode_cmd(bus_wdata[2:0]);
        mask_set  = (bus_wr && sel == RS_IRQ_SET) ? bus_wdata[IRQ_W-1:0] : '0;
        mask_clr  = (bus_wr && sel == RS_IRQ_CLR) ? bus_wdata[IRQ_W-1:0] : '0;
        stat_rd   = bus_rd && (sel == RS_STAT);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                RS_CFG:      bus_rdata[0] = single;
                RS_CMP:      bus_rdata[CNT_W-1:0] = cmp;
                RS_IRQ_MASK: bus_rdata[IRQ_W-1:0] = mask;
                RS_STAT: begin
                    bus_rdata[IRQ_W-1:0] = flags;
                    bus_rdata[ACT_POS]   = active;
                end
                RS_COUNT:    bus_rdata[CNT_W-1:0] = count;
                default:     bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            single <= 1'b0;
            cmp    <= CNT_W'(RST_CMP);
        end else if (bus_wr) begin
            if (sel == RS_CFG)
                single <= bus_wdata[0];
            if (sel == RS_CMP)
                cmp <= bus_wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
    import evt_timer_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter int          DATA_W  = 16,
    parameter int          IRQ_W   = 8,
    parameter int unsigned TICK_HZ = 100
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  slow_tick,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq
);

    localparam int unsigned RST_CMP = ticks_for_rate(TICK_HZ);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cmp;
    logic             clk_en;
    logic             halted;
    logic             hit;
    logic             active;
    logic             single;
    logic             cmd_valid;
    run_cmd_t         cmd;
    logic [IRQ_W-1:0] flags;
    logic [IRQ_W-1:0] mask;
    logic [IRQ_W-1:0] mask_set;
    logic [IRQ_W-1:0] mask_clr;
    logic [IRQ_W-1:0] src_evt;
    logic             stat_rd;

    assign active  = clk_en && !halted;
    assign src_evt = {{(IRQ_W-1){1'b0}}, hit};

    evt_bus_regs #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W), .RST_CMP(RST_CMP)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .active(active), .flags(flags), .mask(mask),
        .cmd_valid(cmd_valid), .cmd(cmd), .single(single), .cmp(cmp),
        .mask_set(mask_set), .mask_clr(mask_clr), .stat_rd(stat_rd)
    );

    evt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .cmd_valid(cmd_valid), .cmd(cmd), .single(single), .cmp(cmp),
        .count(count), .clk_en(clk_en), .halted(halted), .hit(hit)
    );

    evt_irq_unit #(.IRQ_W(IRQ_W)) u_irq (
        .clk(clk), .rst(rst), .src_evt(src_evt),
        .mask_set(mask_set), .mask_clr(mask_clr), .stat_rd(stat_rd),
        .flags(flags), .mask(mask), .irq(irq)
    );

endmodule

// File: rtl/evt_timer_chan_chk.sv
module evt_timer_chan_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int IRQ_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic              clk_en,
    input logic              halted,
    input logic              hit,
    input logic              single,
    input logic [IRQ_W-1:0]  flags,
    input logic [IRQ_W-1:0]  mask
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !clk_en && !halted && flags == '0 && !irq));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == '0 || count == $past(count) + CNT_W'(1)));

    assert_match_flag_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> flags[0]);

    assert_single_park_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && single) |=> (halted && count == '0));

    assert_off_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0 && bus_wdata[1]) |=> !clk_en);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags[0] && mask[0]));

    assert_stat_read_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd6) |-> !irq);

endmodule

bind evt_timer_chan evt_timer_chan_chk #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)
) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
    .count(count), .clk_en(clk_en), .halted(halted), .hit(hit),
    .single(single), .flags(flags), .mask(mask)
);

// File: tb/sim_evt_timer_chan.sv
`timescale 1ns/1ps
module sim_evt_timer_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    evt_timer_chan u0 (
        .clk(clk), .rst(rst), .slow_tick(slow_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int    nvec = 0;
    int    nbad = 0;
    int    ncyc = 0;
    int    tper = 0;
    string req  = "R1";

    // behavioural reference state
    bit       m_en, m_halt, m_single, m_flag;
    int       m_cnt, m_cmp;
    bit [7:0] m_mask;

    task automatic cyc(input bit w, input bit r, input logic [2:0] a, input logic [15:0] d);
        logic [15:0] er;
        bit ei, hitm, bad;
        int ceff;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        slow_tick = (tper > 0) && (ncyc % tper == 0);
        #1;
        er = '0;
        if (r) begin
            case (a)
                3'd1: er = {15'd0, m_single};
                3'd2: er = m_cmp[15:0];
                3'd5: er = {8'd0, m_mask};
                3'd6: er = {7'd0, (m_en && !m_halt), 7'd0, m_flag};
                3'd7: er = m_cnt[15:0];
                default: er = '0;
            endcase
        end
        ei = m_flag && m_mask[0] && !(r && a == 3'd6);
        nvec++;
        bad = 0;
        if (bus_rdata !== er) begin
            $display("FAIL %s cycle %0d addr %0d: rdata=%h expected %h", req, ncyc, a, bus_rdata, er);
            bad = 1;
        end
        if (irq !== ei) begin
            $display("FAIL %s cycle %0d: irq=%b expected %b", req, ncyc, irq, ei);
            bad = 1;
        end
        if (bad) nbad++;
        // advance reference by one clock
        ceff = (m_cmp == 0) ? 1 : m_cmp;
        hitm = 0;
        if (w && a == 3'd0) begin
            if (d[1]) m_en = 0;
            else if (d[0]) m_en = 1;
            if (d[2]) begin m_cnt = 0; m_halt = 0; end
        end else if (slow_tick && m_en && !m_halt) begin
            if (m_cnt + 1 >= ceff) begin
                hitm = 1; m_cnt = 0;
                if (m_single) m_halt = 1;
            end else begin
                m_cnt++;
            end
        end
        if (w && a == 3'd1) m_single = d[0];
        if (w && a == 3'd2) m_cmp = int'(d);
        if (w && a == 3'd3) m_mask = m_mask | d[7:0];
        if (w && a == 3'd4) m_mask = m_mask & ~d[7:0];
        if (hitm) m_flag = 1;
        else if (r && a == 3'd6) m_flag = 0;
        ncyc++;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(1'b0, 1'b1, a, 16'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 3'd7, 16'd0);
    endtask

    initial begin
        #(150000 * 5);
        $display("FAIL watchdog: run did not finish, expected completion");
        nbad++;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_en = 0; m_halt = 0; m_single = 0; m_flag = 0;
        m_cnt = 0; m_cmp = 328; m_mask = 8'd0;

        // R1: reset values, compare preloaded with 328
        req = "R1";
        rd(3'd2); rd(3'd1); rd(3'd5); rd(3'd6); rd(3'd7);
        // R2: ticks while disabled leave the count alone
        req = "R2"; tper = 1; idle(5); tper = 0;

        // R9: register readback and write-only addresses
        req = "R9";
        wr(3'd2, 16'd5); rd(3'd2); wr(3'd1, 16'd0); rd(3'd1);
        rd(3'd0); rd(3'd3); rd(3'd4); cyc(1'b0, 1'b0, 3'd2, 16'd0);

        // R7: enable the compare interrupt
        req = "R7"; wr(3'd3, 16'h0001); rd(3'd5);

        // R3: periodic events with a tick every third cycle
        req = "R5"; wr(3'd0, 16'h0005);
        req = "R3"; tper = 3; idle(40);
        // R8: status read clears flag and silences irq
        req = "R8"; rd(3'd6); rd(3'd6); idle(4);

        // R5: disable, enable+disable together, re-enable, restart on tick cycles
        req = "R5"; tper = 1;
        wr(3'd0, 16'h0002); idle(8);
        wr(3'd0, 16'h0003); idle(5);
        wr(3'd0, 16'h0001); idle(3);
        wr(3'd0, 16'h0004); idle(3);
        wr(3'd0, 16'h0001); idle(6);

        // R4: single-shot parks until restart
        req = "R4"; wr(3'd1, 16'h0001); wr(3'd0, 16'h0005);
        tper = 2; idle(30); rd(3'd6); idle(10);
        wr(3'd0, 16'h0004); idle(20);

        // R6: compare of zero matches every tick
        req = "R6"; wr(3'd1, 16'h0000); wr(3'd2, 16'h0000); wr(3'd0, 16'h0005);
        tper = 1; idle(6);
        // R8: read colliding with a match keeps the flag
        req = "R8"; for (int i = 0; i < 5; i++) rd(3'd6);
        tper = 0; rd(3'd6); rd(3'd6);

        // R7: mask clear-all and set
        req = "R7"; tper = 1; idle(2);
        wr(3'd4, 16'h00FF); idle(4); rd(3'd5);
        wr(3'd3, 16'h0001); idle(3);
        wr(3'd3, 16'h00F0); rd(3'd5);

        // R10: full range compare 0xFFFF
        req = "R10"; wr(3'd4, 16'h00FF); wr(3'd2, 16'hFFFF); wr(3'd0, 16'h0005);
        tper = 1; idle(65540); rd(3'd6);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule